// File: doc/BRIEF.md
# Sampled Multi-Size Cache Miss Estimator

This block sits beside a last-level cache and listens to its access stream without ever pushing back on it. For a fixed set of six smaller cache sizes (1, 2, 4, 8, 12 and 16 sixteenths of the full cache), it estimates how many of the sampled accesses would miss. Only one set out of every 2^SAMP_W is observed. Each emulated size is a tag-only store with the associativity and true-LRU replacement of the real cache.

The size of each level is set by the number of cache colors it owns. A per-level color map sends each address region to one of that level's colors, and this also allows the non-power-of-two 12/16 size. Sampled block addresses wait in a small queue. A sequencer then presents the head entry to the six levels in turn, one level per cycle.

Per-level access and miss counters and a queue drop counter are visible at the outputs. They are zeroed by an interval-end pulse, so that software or a policy engine can read them once per interval.

Top module: `cache_size_emu`

## Requirements
- R1: An access is taken only when `acc_vld_i` is high and `blk_addr_i[SAMP_W-1:0]` is zero. Every other access leaves all counters and all tag state unchanged.
- R2: Taken accesses enter a queue of FIFO_DEPTH entries. A taken access that arrives while the queue already holds FIFO_DEPTH entries is discarded, and the drop counter rises by one.
- R3: The queue head visits levels 0 to 5 in ascending order, one level per cycle. The head is retired after level 5. The access counter of level k rises in the cycle that level k is visited, which is the (k+1)-th clock edge after the access is queued from an empty queue.
- R4: Block address fields, from the LSB up, are: SAMP_W sample bits, then OFF_W set-offset bits, then CLR_W region bits, then the upper tag bits. Level k owns C_k = 2^CLR_W·{1,2,4,8,12,16}[k]/16 colors and 2^OFF_W·C_k sets. Its set is (map_k[region] mod C_k)·2^OFF_W + offset. Here map_k[r] is `lvl_map_i[(k·2^CLR_W + r)·CLR_W +: CLR_W]`.
- R5: Each set holds WAYS tags of region plus upper tag bits. A hit needs a valid matching tag. A miss writes the tag into the least recently used way, and every visit makes the touched way the most recent.
- R6: The miss counter of a level rises by one for each visit that misses in that level.
- R7: All counters saturate at 2^CNT_W-1 rather than wrapping.
- R8: A high `intv_clr_i` zeroes every counter at the next edge and overrides an increment in the same cycle. Tag contents survive the clear.
- R9: After reset, all counters read zero and no way holds a valid tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | An access to the real cache is present |
| blk_addr_i | input | BLK_W | Block address of that access (byte offset removed) |
| intv_clr_i | input | 1 | Interval-end pulse clearing all counters |
| lvl_map_i | input | 6·2^CLR_W·CLR_W | Region-to-color map of every level |
| acc_cnt_o | output | 6·CNT_W | Per-level visit counters, level k at [k·CNT_W +: CNT_W] |
| miss_cnt_o | output | 6·CNT_W | Per-level miss counters, same packing |
| drop_cnt_o | output | CNT_W | Count of sampled accesses lost to a full queue |

## Verification
A small bench configuration with 2 ways and 8-bit counters makes the expected counts easy to derive by arithmetic.

- **Replacement order.** The sequence A B A C A B exposes the replacement order: a FIFO or random victim choice gives more than four misses.
- **Color mapping.** A sweep over all 16 regions with two tags separates all six levels by size. The 12-color level gets exactly 48 misses only if regions 12 to 15 fold modulo 12. A clamped or unfolded index gives a different count, and an index that ignores the offset field doubles the misses in the offset sweep.
- **Queue and counters.** A six-access burst into an empty queue must drop exactly two accesses. A 260-access run must hold the counters at 255 instead of wrapping to 4. A re-access after a clear must hit, which would fail if the clear also wiped the tags.

// File: rtl/cemu_pkg.sv
package cemu_pkg;
  localparam int unsigned NUM_LVL = 6;

  // emulated size of level k in sixteenths of the full cache
  function automatic int unsigned lvl_sixteenths(input int unsigned k);
    case (k)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 8;
      4:       return 12;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cemu_sat_cnt.sv
module cemu_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R8
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX); // R7
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o)); // R6
endmodule

// File: rtl/cemu_fifo.sv
module cemu_fifo
  import cemu_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = idx_width(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= ptr_next(wr_q);
      end
      if (pop_i) rd_q <= ptr_next(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  AST_FIFO_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R2
  AST_FIFO_NO_UDF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R3
endmodule

// File: rtl/cemu_level.sv
module cemu_level
  import cemu_pkg::*;
#(
  parameter int unsigned TAG_W      = 11,
  parameter int unsigned OFF_W      = 1,
  parameter int unsigned CLR_W      = 4,
  parameter int unsigned NUM_CLR    = 16,
  parameter int unsigned LVL_COLORS = 16,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned CNT_W      = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic [NUM_CLR*CLR_W-1:0] map_i,
  output logic [CNT_W-1:0]         acc_cnt_o,
  output logic [CNT_W-1:0]         miss_cnt_o
);
  localparam int unsigned SPC   = 1 << OFF_W;
  localparam int unsigned SETS  = LVL_COLORS * SPC;
  localparam int unsigned IDX_W = idx_width(SETS);
  localparam int unsigned AGE_W = idx_width(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  logic [CLR_W-1:0] region, raw_col;
  logic [31:0]      col_w, idx_w;
  logic [IDX_W-1:0] idx;
  logic [WAYS-1:0]  hit_v;
  logic             hit;
  logic [AGE_W-1:0] hit_way, vic_way, tgt_way, tgt_age;

  // set index: folded color of the region, then the offset within the color
  always_comb begin
    region  = tag_i[CLR_W-1:0];
    raw_col = map_i[int'(region)*CLR_W +: CLR_W];
    col_w   = 32'(raw_col) % 32'(LVL_COLORS);
    idx_w   = col_w * 32'(SPC) + 32'(off_i);
    idx     = idx_w[IDX_W-1:0];
  end

  always_comb begin
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_v[w] = vld_q[idx][w] && (tag_q[idx][w] == tag_i);
      if (hit_v[w]) hit_way = AGE_W'(w);
      if (age_q[idx][w] == AGE_W'(WAYS - 1)) vic_way = AGE_W'(w);
    end
    hit     = |hit_v;
    tgt_way = hit ? hit_way : vic_way;
    tgt_age = age_q[idx][tgt_way];
  end

  // ages form a permutation per set; invalid ways always stay oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == tgt_way)          age_q[idx][w] <= '0;
        else if (age_q[idx][w] < tgt_age)  age_q[idx][w] <= age_q[idx][w] + 1'b1;
      end
      if (!hit) begin
        tag_q[idx][tgt_way] <= tag_i;
        vld_q[idx][tgt_way] <= 1'b1;
      end
    end
  end

  cemu_sat_cnt #(.CNT_W(CNT_W)) u_acc_cnt (
    .clk_i, .rst_ni, .clr_i, .inc_i(en_i), .cnt_o(acc_cnt_o)
  );

  cemu_sat_cnt #(.CNT_W(CNT_W)) u_miss_cnt (
    .clk_i, .rst_ni, .clr_i, .inc_i(en_i && !hit), .cnt_o(miss_cnt_o)
  );

  AST_HIT_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> $onehot0(hit_v)); // R5
  AST_LRU_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> age_q[$past(idx)][$past(tgt_way)] == '0); // R5
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> idx_w < 32'(SETS)); // R4
  AST_MISS_LE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o <= acc_cnt_o); // R6
endmodule

// File: rtl/cache_size_emu.sv
module cache_size_emu
  import cemu_pkg::*;
#(
  parameter int unsigned BLK_W      = 18,
  parameter int unsigned SAMP_W     = 6,
  parameter int unsigned OFF_W      = 1,
  parameter int unsigned CLR_W      = 4,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                acc_vld_i,
  input  logic [BLK_W-1:0]                    blk_addr_i,
  input  logic                                intv_clr_i,
  input  logic [NUM_LVL*(1<<CLR_W)*CLR_W-1:0] lvl_map_i,
  output logic [NUM_LVL*CNT_W-1:0]            acc_cnt_o,
  output logic [NUM_LVL*CNT_W-1:0]            miss_cnt_o,
  output logic [CNT_W-1:0]                    drop_cnt_o
);
  localparam int unsigned NUM_CLR = 1 << CLR_W;
  localparam int unsigned Q_W     = BLK_W - SAMP_W;
  localparam int unsigned TAG_W   = Q_W - OFF_W;
  localparam int unsigned LVL_W   = idx_width(NUM_LVL);
  localparam int unsigned MAP_W   = NUM_CLR * CLR_W;
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(NUM_LVL - 1);

  logic             smp, push, pop, drop_inc;
  logic             q_empty, q_full;
  logic [Q_W-1:0]   q_head;
  logic [LVL_W-1:0] lvl_q;

  assign smp      = acc_vld_i && (blk_addr_i[SAMP_W-1:0] == '0);
  assign push     = smp && !q_full;
  assign drop_inc = smp && q_full;
  assign pop      = !q_empty && (lvl_q == LVL_LAST);

  cemu_fifo #(.DATA_W(Q_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (blk_addr_i[BLK_W-1:SAMP_W]),
    .pop_i  (pop),
    .data_o (q_head),
    .empty_o(q_empty),
    .full_o (q_full)
  );

  // level sequencer: one level per cycle while the queue is non-empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= '0;
    else if (!q_empty) lvl_q <= (lvl_q == LVL_LAST) ? '0 : lvl_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    localparam int unsigned LC = NUM_CLR * lvl_sixteenths(k) / 16;
    logic en;
    assign en = !q_empty && (lvl_q == LVL_W'(k));

    cemu_level #(
      .TAG_W(TAG_W), .OFF_W(OFF_W), .CLR_W(CLR_W), .NUM_CLR(NUM_CLR),
      .LVL_COLORS(LC), .WAYS(WAYS), .CNT_W(CNT_W)
    ) u_level (
      .clk_i, .rst_ni,
      .clr_i     (intv_clr_i),
      .en_i      (en),
      .tag_i     (q_head[Q_W-1:OFF_W]),
      .off_i     (q_head[OFF_W-1:0]),
      .map_i     (lvl_map_i[k*MAP_W +: MAP_W]),
      .acc_cnt_o (acc_cnt_o[k*CNT_W +: CNT_W]),
      .miss_cnt_o(miss_cnt_o[k*CNT_W +: CNT_W])
    );
  end

  cemu_sat_cnt #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk_i, .rst_ni, .clr_i(intv_clr_i), .inc_i(drop_inc), .cnt_o(drop_cnt_o)
  );

  AST_LVL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_empty && lvl_q != LVL_LAST) |=> lvl_q == $past(lvl_q) + 1'b1); // R3
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_empty |=> $stable(lvl_q)); // R3
  AST_LVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_LAST); // R3
  AST_DROP_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_inc && !intv_clr_i) |=> drop_cnt_o != '0); // R2
endmodule

// File: tb/cache_size_emu_tb.sv
module cache_size_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL    = 6;
  localparam int CW    = 8;
  localparam int BLK_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_vld = 1'b0;
  logic [BLK_W-1:0]  blk_addr = '0;
  logic              intv_clr = 1'b0;
  logic [NL*16*4-1:0] lvl_map = '0;
  logic [NL*CW-1:0]  acc_cnt, miss_cnt;
  logic [CW-1:0]     drop_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int exp_m [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_size_emu #(
    .BLK_W(BLK_W), .SAMP_W(6), .OFF_W(1), .CLR_W(4),
    .WAYS(2), .FIFO_DEPTH(4), .CNT_W(CW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .blk_addr_i(blk_addr),
    .intv_clr_i(intv_clr), .lvl_map_i(lvl_map),
    .acc_cnt_o(acc_cnt), .miss_cnt_o(miss_cnt), .drop_cnt_o(drop_cnt)
  );

  // {upper tag 7b, region 4b, offset 1b, sample bits 6b}
  function automatic logic [BLK_W-1:0] mk(input int hi, input int rg, input int off);
    return {7'(hi), 4'(rg), 1'(off), 6'b0};
  endfunction

  function automatic int acc_of(input int k);
    return int'(acc_cnt[k*CW +: CW]);
  endfunction

  function automatic int miss_of(input int k);
    return int'(miss_cnt[k*CW +: CW]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_lvls(input string req, input int exp_acc);
    for (int k = 0; k < NL; k++) begin
      chk(req, $sformatf("level %0d accesses", k), acc_of(k), exp_acc);
      chk(req, $sformatf("level %0d misses", k), miss_of(k), exp_m[k]);
    end
  endtask

  task automatic send(input logic [BLK_W-1:0] a);
    @(negedge clk);
    acc_vld  = 1'b1;
    blk_addr = a;
    @(negedge clk);
    acc_vld  = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    intv_clr = 1'b1;
    @(negedge clk);
    intv_clr = 1'b0;
  endtask

  function automatic int sum_all();
    int s = int'(drop_cnt);
    for (int k = 0; k < NL; k++) s += acc_of(k) + miss_of(k);
    return s;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    // identity region-to-color maps in every level
    for (int k = 0; k < NL; k++)
      for (int r = 0; r < 16; r++)
        lvl_map[(k*16 + r)*4 +: 4] = 4'(r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9", "sum of all counters after reset", sum_all(), 0);

    // R1: unsampled and invalid accesses are ignored
    send(mk(3, 2, 0) | 18'd5);
    send(mk(4, 7, 1) | 18'd32);
    @(negedge clk); acc_vld = 1'b0; blk_addr = mk(5, 1, 0);
    repeat (8) @(negedge clk);
    chk("R1", "sum of all counters after ignored traffic", sum_all(), 0);

    // R3: levels visited in ascending order, one per cycle
    @(negedge clk); acc_vld = 1'b1; blk_addr = mk(100, 5, 0);
    @(negedge clk); acc_vld = 1'b0;
    for (int k = 0; k < NL; k++) begin
      @(posedge clk); #1;
      chk("R3", $sformatf("level %0d visited at edge %0d", k, k+1), acc_of(k), 1);
      if (k < NL-1)
        chk("R3", $sformatf("level %0d not yet visited", k+1), acc_of(k+1), 0);
    end
    repeat (4) @(negedge clk);

    // R5/R6: true LRU, A B A C A B -> 4 misses with 2 ways
    pulse_clr();
    send(mk(1, 0, 0)); send(mk(2, 0, 0)); send(mk(1, 0, 0));
    send(mk(3, 0, 0)); send(mk(1, 0, 0)); send(mk(2, 0, 0));
    exp_m = '{4, 4, 4, 4, 4, 4};
    chk_lvls("R5", 6);

    // R4/R6: region sweep, 2 tags x 16 regions, two passes
    pulse_clr();
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 16; r++) send(mk(10 + t, r, 0));
    exp_m = '{64, 64, 64, 64, 48, 32};
    chk_lvls("R4", 64);

    // R4: the offset field selects separate sets
    pulse_clr();
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 2; t++)
        for (int o = 0; o < 2; o++) send(mk(20 + t, 0, o));
    exp_m = '{4, 4, 4, 4, 4, 4};
    chk_lvls("R4", 8);

    // R2: six back-to-back sampled accesses into an empty queue of 4
    pulse_clr();
    @(negedge clk);
    acc_vld = 1'b1;
    for (int i = 0; i < 6; i++) begin
      blk_addr = mk(30 + i, 1, 0);
      @(negedge clk);
    end
    acc_vld = 1'b0;
    repeat (40) @(negedge clk);
    chk("R2", "drop counter", int'(drop_cnt), 2);
    exp_m = '{4, 4, 4, 4, 4, 4};
    chk_lvls("R2", 4);

    // R8: clear zeroes every counter
    pulse_clr();
    chk("R8", "sum of all counters after clear", sum_all(), 0);

    // R7: 260 misses saturate at 255
    for (int i = 0; i < 260; i++) send(mk(40 + (i % 3), 0, 0));
    exp_m = '{255, 255, 255, 255, 255, 255};
    chk_lvls("R7", 255);

    // R8: tags survive a clear; the last line re-hits
    pulse_clr();
    chk("R8", "sum after clear following saturation", sum_all(), 0);
    send(mk(41, 0, 0));
    exp_m = '{0, 0, 0, 0, 0, 0};
    chk_lvls("R8", 1);

    done = 1;
    summary();
  end
endmodule